// File: doc/BRIEF.md
# Bitstream Refill Ring Buffer

This block sits between a read-only memory holding a coded video bitstream and a variable-length decoder. The decoder takes a different number of bits on each step. The block keeps a 128-bit circular store made of two 64-bit halves. It always presents the 32 bits that start at its read pointer, and the window may straddle word boundaries or the end of the ring.

When one half has been drained, the block requests the next 64-bit word from the memory at once. The memory answers one cycle later, and the word lands in the drained half. A bit counter tracks how much unread data is held. The decoder sees a valid window only when at least 32 bits are available. An address limit input marks the end of the stream, and no word is requested at or beyond it.

Top module: `bs_refill_ring`

## Requirements
- R1: While reset is held, and until both halves have first been filled, `win_valid` stays low.
- R2: After reset release, word addresses 0 and 1 are requested on the first two cycles, back to back. `win_valid` first rises on the fourth cycle after release, with the window showing stream bits 0 to 31.
- R3: The stream is read MSB first: bit 63 of a memory word is the earliest stream bit of that word. `win_data[31]` is the stream bit at the read pointer and `win_data[0]` is 31 bits later. This holds across word boundaries and across the wrap of the 7-bit pointer at 128.
- R4: When `win_valid` is high and `take_len` is 0 to 32, the pointer advances by `take_len` at the clock edge. A length of 0 leaves the window unchanged.
- R5: A `take_len` above 32, or any `take_len` presented while `win_valid` is low, is ignored and leaves the pointer and window unchanged.
- R6: A read is issued in the same cycle in which the unread count after this cycle's update would be 64 or less. Successive reads use consecutive addresses. At one 32-bit take per cycle, `win_valid` never drops while stream words remain.
- R7: `win_valid` is low whenever fewer than 32 unread bits are held, including at the end of the stream.
- R8: No read is issued at an address equal to or above `addr_limit`. A stream of N words produces exactly N reads.
- R9: The unread count never exceeds 128 bits, so no refill overwrites unread data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_len | input | 6 | Bits consumed this cycle (0 to 32 accepted) |
| addr_limit | input | 10 | Number of stream words; reads stop at this address |
| win_data | output | 32 | Bit-aligned window starting at the read pointer, earliest bit in bit 31 |
| win_valid | output | 1 | Window holds at least 32 unread bits |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory word address |
| mem_rd_data | input | 64 | Memory read data, valid one cycle after the strobe |

## Verification
The bench aims at windows that straddle a word boundary and the ring wrap. An extractor that indexed bits in the wrong order, or dropped the modulo, would show shifted or reversed bits there. It holds a nonzero `take_len` through the fill phase and then sends an oversized length. A design that accepted either would skip stream bits, and the next window would not match. A sustained 32-bit-per-cycle burst exposes a refill trigger that fires one cycle late, because the window then goes invalid. The drain to the end of the stream catches a design that reads past the limit or keeps the window valid with fewer than 32 bits held.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int DEF_WORD_W = 64;
  localparam int DEF_WIN_W  = 32;
  localparam int DEF_AW     = 10;
endpackage

// File: rtl/bsr_ring_store.sv
module bsr_ring_store #(
  parameter int WORD_W = bsr_pkg::DEF_WORD_W,
  localparam int RING_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_half,
  input  logic [WORD_W-1:0] wr_word,
  output logic [RING_W-1:0] ring_bits
);
  // Ring position j of a half holds word bit WORD_W-1-j (earliest bit first).
  logic [WORD_W-1:0] word_rev;

  always_comb begin
    for (int j = 0; j < WORD_W; j++) begin
      word_rev[j] = wr_word[WORD_W-1-j];
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [WORD_W-1:0] half_q;
    logic              half_we;

    assign half_we = wr_en && (wr_half == 1'(h));

    always_ff @(posedge clk) begin
      if (half_we) begin
        half_q <= word_rev;
      end
    end

    assign ring_bits[h*WORD_W +: WORD_W] = half_q;
  end
endmodule

// File: rtl/bsr_window.sv
module bsr_window #(
  parameter int WORD_W = bsr_pkg::DEF_WORD_W,
  parameter int WIN_W  = bsr_pkg::DEF_WIN_W,
  localparam int RING_W = 2 * WORD_W,
  localparam int PTR_W  = $clog2(RING_W)
) (
  input  logic [RING_W-1:0] ring_bits,
  input  logic [PTR_W-1:0]  ptr,
  output logic [WIN_W-1:0]  win
);
  for (genvar k = 0; k < WIN_W; k++) begin : g_tap
    logic [PTR_W-1:0] idx;
    assign idx = ptr + PTR_W'(k);
    assign win[WIN_W-1-k] = ring_bits[idx];
  end
endmodule

// File: rtl/bsr_refill_ctrl.sv
module bsr_refill_ctrl #(
  parameter int WORD_W = bsr_pkg::DEF_WORD_W,
  parameter int WIN_W  = bsr_pkg::DEF_WIN_W,
  parameter int AW     = bsr_pkg::DEF_AW,
  localparam int RING_W = 2 * WORD_W,
  localparam int PTR_W  = $clog2(RING_W),
  localparam int LVL_W  = $clog2(RING_W) + 1,
  localparam int TL_W   = $clog2(WIN_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TL_W-1:0]  take_len,
  input  logic [AW-1:0]    addr_limit,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             win_valid,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  output logic             wr_en,
  output logic             wr_half
);
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q;
  logic [LVL_W:0]   lvl_sum;
  logic [AW-1:0]    addr_q, addr_d;
  logic             pend_q, half_q, primed_q, primed_d;
  logic             take_ok, issue;
  logic [LVL_W:0]   taken;

  // next-state logic
  always_comb begin
    take_ok  = win_valid && (take_len <= TL_W'(WIN_W));
    taken    = take_ok ? (LVL_W+1)'(take_len) : '0;
    lvl_sum  = {1'b0, level_q} + (pend_q ? (LVL_W+1)'(WORD_W) : '0) - taken;
    issue    = (lvl_sum <= (LVL_W+1)'(WORD_W)) && (addr_q < addr_limit);
    rd_ptr_d = rd_ptr_q + PTR_W'(take_len);
    addr_d   = addr_q + 1'b1;
    primed_d = primed_q | (pend_q & ~issue);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      level_q  <= '0;
      addr_q   <= '0;
      pend_q   <= 1'b0;
      half_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      if (take_ok) rd_ptr_q <= rd_ptr_d;
      level_q  <= lvl_sum[LVL_W-1:0];
      if (issue)  addr_q <= addr_d;
      pend_q   <= issue;
      if (pend_q) half_q <= ~half_q;
      primed_q <= primed_d;
    end
  end

  assign rd_ptr    = rd_ptr_q;
  assign level     = level_q;
  assign win_valid = primed_q && (level_q >= LVL_W'(WIN_W));
  assign mem_rd_en = issue;
  assign mem_addr  = addr_q;
  assign wr_en     = pend_q;
  assign wr_half   = half_q;
endmodule

// File: rtl/bs_refill_ring.sv
module bs_refill_ring #(
  parameter int WORD_W = bsr_pkg::DEF_WORD_W,
  parameter int WIN_W  = bsr_pkg::DEF_WIN_W,
  parameter int AW     = bsr_pkg::DEF_AW,
  localparam int RING_W = 2 * WORD_W,
  localparam int PTR_W  = $clog2(RING_W),
  localparam int LVL_W  = $clog2(RING_W) + 1,
  localparam int TL_W   = $clog2(WIN_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TL_W-1:0]   take_len,
  input  logic [AW-1:0]     addr_limit,
  output logic [WIN_W-1:0]  win_data,
  output logic              win_valid,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rd_data
);
  logic [PTR_W-1:0]  rd_ptr_w;
  logic [LVL_W-1:0]  level_w;
  logic [RING_W-1:0] ring_w;
  logic              wr_en_w, wr_half_w;

  bsr_refill_ctrl #(.WORD_W(WORD_W), .WIN_W(WIN_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take_len(take_len), .addr_limit(addr_limit),
    .rd_ptr(rd_ptr_w), .level(level_w), .win_valid(win_valid),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .wr_en(wr_en_w), .wr_half(wr_half_w)
  );

  bsr_ring_store #(.WORD_W(WORD_W)) u_store (
    .clk(clk), .wr_en(wr_en_w), .wr_half(wr_half_w),
    .wr_word(mem_rd_data), .ring_bits(ring_w)
  );

  bsr_window #(.WORD_W(WORD_W), .WIN_W(WIN_W)) u_win (
    .ring_bits(ring_w), .ptr(rd_ptr_w), .win(win_data)
  );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int WORD_W = 64,
  parameter int WIN_W  = 32,
  parameter int AW     = 10,
  localparam int RING_W = 2 * WORD_W,
  localparam int PTR_W  = $clog2(RING_W),
  localparam int LVL_W  = $clog2(RING_W) + 1,
  localparam int TL_W   = $clog2(WIN_W) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TL_W-1:0]  take_len,
  input logic [AW-1:0]    addr_limit,
  input logic             win_valid,
  input logic             mem_rd_en,
  input logic [AW-1:0]    mem_addr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [LVL_W-1:0] level
);
  assert_level_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(RING_W));

  assert_addr_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr < addr_limit));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_addr == $past(mem_addr) + 1'b1));

  assert_valid_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (level >= LVL_W'(WIN_W)));

  assert_ignore_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_valid || take_len > TL_W'(WIN_W)) |=> (rd_ptr == $past(rd_ptr)));

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && take_len <= TL_W'(WIN_W)) |=>
      (rd_ptr == $past(rd_ptr) + PTR_W'($past(take_len))));
endmodule

bind bs_refill_ring bsr_checker #(.WORD_W(WORD_W), .WIN_W(WIN_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_len(take_len), .addr_limit(addr_limit),
  .win_valid(win_valid), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .rd_ptr(rd_ptr_w), .level(level_w)
);

// File: tb/bs_refill_ring_bench.sv
`timescale 1ns/1ps
module bs_refill_ring_bench;
  localparam int WORD_W = 64;
  localparam int WIN_W  = 32;
  localparam int AW     = 10;
  localparam int TL_W   = 6;
  localparam int NWORDS = 24;
  localparam int TOTAL  = NWORDS * WORD_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [TL_W-1:0]   take_len;
  logic [AW-1:0]     addr_limit;
  logic [WIN_W-1:0]  win_data;
  logic              win_valid;
  logic              mem_rd_en;
  logic [AW-1:0]     mem_addr;
  logic [WORD_W-1:0] mem_rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int ofs = 0;
  int rd_cnt;
  logic [WIN_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  bs_refill_ring u_bs_refill_ring (
    .clk(clk), .rst_n(rst_n), .take_len(take_len), .addr_limit(addr_limit),
    .win_data(win_data), .win_valid(win_valid), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [WORD_W-1:0] word_at(int i);
    logic [31:0] a;
    a = 32'(i);
    return {a * 32'h9E3779B9, (a * 32'h85EBCA6B) ^ 32'h5BD1E995};
  endfunction

  function automatic logic [WIN_W-1:0] stream_win(int o);
    logic [WIN_W-1:0] r;
    logic [WORD_W-1:0] w;
    for (int k = 0; k < WIN_W; k++) begin
      w = word_at((o + k) / WORD_W);
      r[WIN_W-1-k] = w[WORD_W-1-((o + k) % WORD_W)];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory stub: one-cycle synchronous read
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= word_at(int'(mem_addr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cnt <= 0;
    else if (mem_rd_en) rd_cnt <= rd_cnt + 1;
  end

  // scoreboard monitor: compares the window one step after the driver queued it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [WIN_W-1:0] e;
        e = exp_q.pop_front();
        check(win_valid && win_data == e, "R3 R4 window", {31'd0, win_valid, win_data}, {32'd1, e});
      end
    end
  end

  // driver: waits for a valid window, queues the expected one, presents a take
  task automatic take(input int n, output int waited);
    waited = 0;
    @(negedge clk);
    while (!win_valid && waited < 1000) begin
      waited++;
      @(negedge clk);
    end
    exp_q.push_back(stream_win(ofs));
    take_len = TL_W'(n);
    if (n <= WIN_W) ofs += n;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    int stalls;
    rst_n = 1'b0;
    take_len = TL_W'(20);   // held during fill: must be ignored (R5)
    addr_limit = AW'(NWORDS);
    repeat (4) @(negedge clk);
    #1 check(!win_valid, "R1 valid in reset", 64'(win_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(mem_rd_en && mem_addr == 0, "R2 first read", {mem_rd_en, 53'd0, mem_addr}, {1'b1, 63'd0});
    check(!win_valid, "R1 cycle0", 64'(win_valid), 0);
    @(negedge clk); #1;
    check(mem_rd_en && mem_addr == 1, "R2 second read", {mem_rd_en, 53'd0, mem_addr}, {1'b1, 53'd0, 10'd1});
    check(!win_valid, "R1 cycle1", 64'(win_valid), 0);
    @(negedge clk); #1;
    check(!mem_rd_en, "R6 ring full no read", 64'(mem_rd_en), 0);
    check(!win_valid, "R1 cycle2", 64'(win_valid), 0);
    @(negedge clk); #1;
    take_len = '0;
    check(win_valid && win_data == stream_win(0), "R2 R5 first window",
          {31'd0, win_valid, win_data}, {32'd1, stream_win(0)});

    take(0, w);
    take(40, w);            // R5: oversized length ignored
    take(32, w);
    take(1, w);
    for (int i = 0; i < 40; i++) begin
      take((i * 7 + 3) % 33, w);
    end
    stalls = 0;
    for (int i = 0; i < 16; i++) begin
      take(32, w);
      stalls += w;
    end
    check(stalls == 0, "R6 sustained take", 64'(stalls), 0);

    while (TOTAL - ofs >= 52) take(32, w);
    take(TOTAL - ofs - 20, w);
    @(negedge clk);
    take_len = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!win_valid, "R7 under 32 bits", 64'(win_valid), 0);
    check(rd_cnt == NWORDS, "R8 read count", 64'(rd_cnt), 64'(NWORDS));
    check(!mem_rd_en, "R8 no read past limit", 64'(mem_rd_en), 0);
    check(exp_q.size() == 0, "R4 queue drained", 64'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule